// File: doc/BRIEF.md
# Receive Gearbox with Block Synchronization

This block rebuilds 66-bit code words from a stream of 16-bit receive words. The bit position at which each code word starts is unknown when the block comes out of reset. The block finds it from the 2-bit sync header that leads every code word. It then keeps checking every header for as long as it runs, so a corrupted link is noticed and the search starts again.

All bits go into an 82-bit accumulator. An occupancy count marks where the next input word lands. A code word is taken from the bottom of the accumulator each time at least 66 bits are held. To move the alignment by one bit (a "slip"), one bit is discarded from the bottom of the accumulator on the next accepted input word. Code words leave only while lock is held. Because 16 bits arrive per accepted word and 66 bits leave per code word, the output strobe pulses on average once every 4.125 input words.

One clock is used throughout. Input words are qualified by a valid strobe, and any cycle with the strobe low leaves the block's state unchanged.

Top module: `rx_block_sync_gearbox`

## Requirements
- R1: Input bit k of a word is received after bit k-1, and all earlier words precede later ones. Output bit 0 is the earliest received bit of the code word, and bits [1:0] are its sync header.
- R2: A sync header is valid when bits [1:0] equal 2'b01 or 2'b10. The values 2'b00 and 2'b11 are both invalid.
- R3: Lock is declared on the 64th consecutive valid header at the current alignment. The code word that carries that header is the first one output, and lock_o rises in the same cycle.
- R4: While unlocked, an invalid header resets the valid-header run. It also discards one bit from the stream, so the alignment advances by one bit position. The search repeats until lock is reached.
- R5: While locked, headers are counted in windows of 64, and the first window begins with the header after the one that gave lock. Fewer than 16 invalid headers in a window keep lock, and code words with invalid headers are still output.
- R6: The 16th invalid header in a window drops lock. Its code word is not output, and the search restarts with a one-bit slip.
- R7: blk_valid_o is high only while lock_o is high.
- R8: blk_valid_o never stays high on two consecutive cycles. Cycles with rx_valid_i low do not change the reassembled stream.
- R9: After reset, lock_o and blk_valid_o are low and the accumulator is empty, with the alignment offset at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Input word qualifier |
| rx_data_i | input | 16 | Input word, bit 0 received first |
| blk_o | output | 66 | Reassembled code word, bits [1:0] are the header |
| blk_valid_o | output | 1 | Code word strobe |
| lock_o | output | 1 | Block lock held |

## Verification
On every cycle the assertions check four things:
- Code words appear only under lock.
- The strobe never fires twice in a row.
- Lock rises together with a code word whose header is valid.
- Lock drops and slips happen only on an invalid header, and the accumulator occupancy stays below one code word between extractions.

Only the bench scenarios can show that reassembly is bit-exact and that lock comes exactly on the 64th header. They also show that an arbitrary start offset is found despite gaps in the input strobe. Finally, they show that 15 bad headers in a window are tolerated, while 16 drop lock, withhold that code word and lead to a later relock.

// File: rtl/rxgb_pkg.sv
package rxgb_pkg;
  typedef enum logic {ST_HUNT = 1'b0, ST_LOCKED = 1'b1} sync_state_e;

  function automatic logic hdr_ok(input logic [1:0] hdr);
    return hdr[0] ^ hdr[1];
  endfunction
endpackage

// File: rtl/rxgb_align.sv
module rxgb_align #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 66
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  input  logic             slip_i,
  output logic             emit_o,
  output logic [OUT_W-1:0] word_o
);
  localparam int BUF_W = IN_W + OUT_W;
  localparam int PTR_W = $clog2(BUF_W + 1);

  logic [BUF_W-1:0] acc_q, acc_d, merged, dropped;
  logic [PTR_W-1:0] fill_q, fill_d, avail;
  logic             slip_pend_q;

  always_comb begin
    merged  = acc_q | (BUF_W'(in_data_i) << fill_q);
    // pending slip discards the oldest bit of this update
    dropped = merged >> slip_pend_q;
    avail   = fill_q + PTR_W'(IN_W) - PTR_W'(slip_pend_q);
    emit_o  = in_valid_i && (avail >= PTR_W'(OUT_W));
    word_o  = dropped[OUT_W-1:0];
    acc_d   = acc_q;
    fill_d  = fill_q;
    if (in_valid_i) begin
      acc_d  = emit_o ? (dropped >> OUT_W) : dropped;
      fill_d = emit_o ? (avail - PTR_W'(OUT_W)) : avail;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      fill_q      <= '0;
      slip_pend_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
      if (slip_i)          slip_pend_q <= 1'b1;
      else if (in_valid_i) slip_pend_q <= 1'b0;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q < PTR_W'(OUT_W)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !slip_i) |=> $stable(fill_q) && $stable(acc_q)); // R8
endmodule

// File: rtl/rxgb_lock.sv
module rxgb_lock
  import rxgb_pkg::*;
#(
  parameter int LOCK_CNT = 64,
  parameter int WIN_LEN  = 64,
  parameter int BAD_LIM  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hdr_chk_i,
  input  logic [1:0] hdr_i,
  output logic       lock_o,
  output logic       lock_next_o,
  output logic       slip_o
);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam int BW = $clog2(BAD_LIM + 1);

  sync_state_e st_q, st_d;
  logic [GW-1:0] good_q, good_d;
  logic [WW-1:0] win_q, win_d, win_inc;
  logic [BW-1:0] bad_q, bad_d, bad_inc;
  logic          ok;

  always_comb begin
    ok      = hdr_ok(hdr_i);
    st_d    = st_q;
    good_d  = good_q;
    win_d   = win_q;
    bad_d   = bad_q;
    slip_o  = 1'b0;
    win_inc = win_q + WW'(1);
    bad_inc = bad_q + BW'(!ok);
    if (hdr_chk_i) begin
      if (st_q == ST_HUNT) begin
        if (!ok) begin
          good_d = '0;
          slip_o = 1'b1;
        end else if (good_q == GW'(LOCK_CNT - 1)) begin
          st_d   = ST_LOCKED;
          good_d = '0;
          win_d  = '0;
          bad_d  = '0;
        end else begin
          good_d = good_q + GW'(1);
        end
      end else begin
        if (bad_inc == BW'(BAD_LIM)) begin
          st_d   = ST_HUNT;
          good_d = '0;
          win_d  = '0;
          bad_d  = '0;
          slip_o = 1'b1;
        end else if (win_inc == WW'(WIN_LEN)) begin
          win_d = '0;
          bad_d = '0;
        end else begin
          win_d = win_inc;
          bad_d = bad_inc;
        end
      end
    end
  end

  assign lock_o      = (st_q == ST_LOCKED);
  assign lock_next_o = (st_d == ST_LOCKED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      win_q  <= '0;
      bad_q  <= '0;
    end else begin
      st_q   <= st_d;
      good_q <= good_d;
      win_q  <= win_d;
      bad_q  <= bad_d;
    end
  end

  AST_DROP_ON_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !lock_next_o) |-> (hdr_chk_i && !hdr_ok(hdr_i))); // R6

  AST_SLIP_ON_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> (hdr_chk_i && !hdr_ok(hdr_i))); // R4

  AST_GAIN_ON_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_o && lock_next_o) |-> (hdr_chk_i && hdr_ok(hdr_i))); // R3
endmodule

// File: rtl/rx_block_sync_gearbox.sv
module rx_block_sync_gearbox #(
  parameter int IN_W     = 16,
  parameter int OUT_W    = 66,
  parameter int LOCK_CNT = 64,
  parameter int WIN_LEN  = 64,
  parameter int BAD_LIM  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [IN_W-1:0]  rx_data_i,
  output logic [OUT_W-1:0] blk_o,
  output logic             blk_valid_o,
  output logic             lock_o
);
  logic             emit, slip, lock_next;
  logic [OUT_W-1:0] word;
  logic [OUT_W-1:0] blk_q;
  logic             blk_valid_q;

  rxgb_align #(.IN_W(IN_W), .OUT_W(OUT_W)) u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(rx_valid_i),
    .in_data_i (rx_data_i),
    .slip_i    (slip),
    .emit_o    (emit),
    .word_o    (word)
  );

  rxgb_lock #(.LOCK_CNT(LOCK_CNT), .WIN_LEN(WIN_LEN), .BAD_LIM(BAD_LIM)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hdr_chk_i  (emit),
    .hdr_i      (word[1:0]),
    .lock_o     (lock_o),
    .lock_next_o(lock_next),
    .slip_o     (slip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q       <= '0;
      blk_valid_q <= 1'b0;
    end else begin
      blk_valid_q <= emit && lock_next;
      if (emit) blk_q <= word;
    end
  end

  assign blk_o       = blk_q;
  assign blk_valid_o = blk_valid_q;

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |-> lock_o); // R7

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |=> !blk_valid_o); // R8

  AST_LOCK_RISE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (blk_valid_o && (blk_o[0] ^ blk_o[1]))); // R3
endmodule

// File: tb/rx_block_sync_gearbox_tb_top.sv
module rx_block_sync_gearbox_tb_top;
  localparam int IN_W  = 16;
  localparam int OUT_W = 66;

  typedef struct {
    logic [OUT_W-1:0] w;
    bit               may_skip;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_valid = 1'b0;
  logic [IN_W-1:0]  rx_data = '0;
  logic [OUT_W-1:0] blk;
  logic             blk_valid, lock;

  exp_t             exp_q[$];
  bit               bitq[$];
  int               checks = 0, errors = 0, matched = 0, gcnt = 0;
  bit               gap_en = 0, got_first = 0, lock_fell = 0, prev_lock = 0, done = 0;
  logic [OUT_W-1:0] first_word;

  always #4 clk = ~clk;

  rx_block_sync_gearbox dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .blk_o(blk), .blk_valid_o(blk_valid), .lock_o(lock)
  );

  function automatic logic [63:0] mix(input int unsigned x);
    logic [63:0] z;
    z = {x, x ^ 32'h5bd1e995};
    z = z ^ (z >> 33);
    z = z * 64'hff51afd7ed558ccd;
    z = z ^ (z >> 33);
    z = z * 64'hc4ceb9fe1a85ec53;
    z = z ^ (z >> 33);
    return z;
  endfunction

  function automatic logic [OUT_W-1:0] blk_word(input int i, input int bad);
    logic [1:0] h;
    h = mix(i + 1000)[0] ? 2'b01 : 2'b10;
    if (bad == 1) h = 2'b00;
    if (bad == 2) h = 2'b11;
    return {mix(i), h};
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_lock && !lock) lock_fell = 1;
      prev_lock = lock;
      if (blk_valid) begin
        checks++;
        if (!got_first) begin first_word = blk; got_first = 1; end
        while (exp_q.size() > 0 && exp_q[0].w != blk && exp_q[0].may_skip) void'(exp_q.pop_front());
        if (exp_q.size() == 0 || exp_q[0].w != blk) begin
          errors++;
          $display("FAIL R1 word mismatch: actual %h expected %h", blk,
                   exp_q.size() > 0 ? exp_q[0].w : '0);
        end else begin
          void'(exp_q.pop_front());
          matched++;
        end
      end
    end
  end

  task automatic drive_word();
    logic [IN_W-1:0] d;
    for (int b = 0; b < IN_W; b++) d[b] = bitq.pop_front();
    @(negedge clk);
    if (gap_en) begin
      gcnt++;
      if (gcnt % 5 == 0) begin
        rx_valid = 1'b0;
        @(negedge clk);
      end
    end
    rx_valid = 1'b1;
    rx_data  = d;
  endtask

  task automatic send_block(input int i, input int bad, input bit push, input bit skip);
    logic [OUT_W-1:0] w;
    exp_t e;
    w = blk_word(i, bad);
    if (push) begin e.w = w; e.may_skip = skip; exp_q.push_back(e); end
    for (int k = 0; k < OUT_W; k++) bitq.push_back(w[k]);
    while (bitq.size() >= IN_W) drive_word();
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx_valid = 1'b0;
    exp_q.delete();
    bitq.delete();
    got_first = 0; matched = 0; lock_fell = 0; prev_lock = 0; gcnt = 0;
    repeat (3) @(negedge clk);
    check(!lock, "R9", "lock after reset", 66'(lock), 66'(0));
    check(!blk_valid, "R9", "valid after reset", 66'(blk_valid), 66'(0));
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // aligned stream: lock on 64th header exactly (R3, R1, R9)
    gap_en = 0;
    do_reset();
    for (int i = 0; i < 200; i++) send_block(i, 0, i >= 63, 0);
    idle(10);
    check(got_first && first_word == blk_word(63, 0), "R3", "first word is block 63",
          first_word, blk_word(63, 0));
    check(matched >= 130, "R1", "aligned word count", 66'(matched), 66'(130));
    check(lock, "R3", "locked at end", 66'(lock), 66'(1));

    // unknown offset with input gaps (R4, R8)
    gap_en = 1;
    do_reset();
    for (int k = 0; k < 23; k++) bitq.push_back(mix(999)[k]);
    for (int i = 0; i < 300; i++) send_block(i, 0, 1, 1);
    idle(10);
    check(lock, "R4", "lock found at offset 23", 66'(lock), 66'(1));
    check(matched >= 150, "R8", "words with gaps", 66'(matched), 66'(150));

    // tolerance, loss of lock, relock (R2, R5, R6, R7)
    gap_en = 0;
    do_reset();
    for (int i = 0; i < 128; i++)
      send_block(i, (i >= 70 && i <= 84) ? ((i % 2) ? 1 : 2) : 0, i >= 63, 0);
    check(lock && !lock_fell, "R5", "15 bad headers keep lock", 66'(lock), 66'(1));
    check(matched >= 60, "R5", "bad-header words still output", 66'(matched), 66'(60));
    for (int i = 128; i < 600; i++) begin
      send_block(i, (i >= 130 && i <= 145) ? ((i % 2) ? 1 : 2) : 0, i != 145, i > 145);
      if (i == 144) check(lock, "R5", "locked before 16th bad", 66'(lock), 66'(1));
      if (i == 147) begin
        check(!lock, "R6", "16th bad drops lock", 66'(lock), 66'(0));
        check(lock_fell, "R2", "00 and 11 both counted", 66'(lock_fell), 66'(1));
      end
    end
    idle(10);
    check(lock, "R6", "relock after search restart", 66'(lock), 66'(1));
    check(!blk_valid || lock, "R7", "valid implies lock", 66'(blk_valid), 66'(lock));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule